// File: doc/BRIEF.md
# Command Line Editor for Serial Input

This block sits between a UART receive FIFO and a command parser. It pulls received ASCII bytes one at a time through a data-present/pop handshake and builds one command line in a small character buffer. Lowercase letters are folded to uppercase before storage, so the parser sees case-insensitive text. A backspace erases the last stored character. A carriage return closes the line and raises a ready flag.

While the ready flag is high, the block pops nothing. The parser reads the finished line through a random-access read port. It then pulses a done input, which empties the buffer and clears every flag.

Every stored character and every effective erase is echoed to a transmit path as a one-cycle write strobe. A byte is only taken while the transmitter reports room, so no echo is ever lost. A line that runs past the buffer size is truncated and marked. A full receive FIFO is latched as an overflow flag.

Top module: `cmd_line_editor`

## Requirements
- R1: rx_pop is high in a cycle exactly when rx_present is high, tx_full is low, line_ready is low and line_done is low; a byte is consumed only on a clock edge where rx_pop is high.
- R2: A consumed printable byte (0x20 to 0x7E) is stored at index line_len when line_len is below DEPTH (16), and line_len rises by one on the following cycle.
- R3: A consumed lowercase letter (0x61 to 0x7A) is stored and echoed as its uppercase form (value minus 0x20); every other printable byte is stored unchanged.
- R4: A consumed backspace (0x08) with line_len above zero lowers line_len by one and echoes the byte 0x08.
- R5: A consumed backspace while line_len is zero leaves line_len at zero and produces no echo.
- R6: A consumed carriage return (0x0D) sets line_ready on the next cycle; it is neither stored nor echoed.
- R7: While line_ready is high, no byte is popped and line_len does not change, whatever rx_present does.
- R8: A line_done pulse clears line_len, line_ready, line_long and overflow on the next cycle.
- R9: A printable byte consumed while line_len equals DEPTH is dropped without echo, leaves line_len unchanged and sets line_long until line_done.
- R10: overflow goes high on the cycle after rx_full is sampled high and stays high until line_done.
- R11: echo_wr is a one-cycle pulse in the cycle after the consuming edge, with echo_byte carrying the echoed value in that same cycle.
- R12: A consumed byte that is neither printable, backspace nor carriage return (for example 0x07, 0x7F, 0xC3) is discarded with no echo and no change to line_len.
- R13: rd_char shows, without a clock, the character stored at position rd_idx of the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Byte at the head of the receive FIFO |
| rx_present | input | 1 | Receive FIFO holds at least one byte |
| rx_full | input | 1 | Receive FIFO is full |
| rx_pop | output | 1 | Pops the head byte of the receive FIFO |
| tx_full | input | 1 | Transmit path cannot accept an echo byte |
| echo_byte | output | 8 | Echo byte for the transmit path |
| echo_wr | output | 1 | One-cycle write strobe for echo_byte |
| line_done | input | 1 | Parser has finished with the line; clears the buffer |
| rd_idx | input | 4 | Read index into the line buffer |
| rd_char | output | 8 | Character stored at rd_idx |
| line_len | output | 5 | Number of characters currently stored |
| line_ready | output | 1 | A carriage return has closed the line |
| line_long | output | 1 | Characters were dropped because the line was full |
| overflow | output | 1 | The receive FIFO was seen full |

## Verification
Directed lines check the separate effects. Mixed-case words show that folding touches only a to z. Backspaces at an empty line and in mid-line show that the length never underflows. A run of eighteen characters separates truncation from storage. Stray control and high bytes are popped but must leave no trace.

A seeded random stream mixes letters, digits, spaces, backspaces, carriage returns, junk bytes and transmit stalls. A model in the bench predicts every pop, echo and length step. Each completed line is read back through the read port, which catches wrong storage positions that the echo stream alone would hide.

Holding the input present while a line is ready, and raising the FIFO-full flag, show that popping stops and that the overflow flag is sticky.

// File: rtl/cle_pkg.sv
package cle_pkg;

  localparam int CHAR_W = 8;

  localparam logic [CHAR_W-1:0] CH_CR = 8'h0D;
  localparam logic [CHAR_W-1:0] CH_BS = 8'h08;

  typedef enum logic [1:0] {
    BK_END,
    BK_ERASE,
    BK_CHAR,
    BK_OTHER
  } byte_kind_e;

  // Sort a received byte into the action it triggers.
  function automatic byte_kind_e classify(input logic [CHAR_W-1:0] b);
    if (b == CH_CR)
      return BK_END;
    else if (b == CH_BS)
      return BK_ERASE;
    else if (b >= 8'h20 && b <= 8'h7E)
      return BK_CHAR;
    else
      return BK_OTHER;
  endfunction

  // Fold lowercase letters to uppercase; leave everything else alone.
  function automatic logic [CHAR_W-1:0] fold_upper(input logic [CHAR_W-1:0] b);
    if (b >= 8'h61 && b <= 8'h7A)
      return b - 8'h20;
    else
      return b;
  endfunction

endpackage

// File: rtl/cle_rx_gate.sv
module cle_rx_gate
  import cle_pkg::*;
(
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              rx_present,
  input  logic              tx_full,
  input  logic              line_ready,
  input  logic              line_done,
  output logic              rx_pop,
  output logic              ev_end,
  output logic              ev_erase_req,
  output logic              ev_char_req,
  output logic [CHAR_W-1:0] char_up
);

  byte_kind_e kind;

  always_comb begin
    rx_pop       = rx_present & ~tx_full & ~line_ready & ~line_done;
    kind         = classify(rx_byte);
    ev_end       = rx_pop && (kind == BK_END);
    ev_erase_req = rx_pop && (kind == BK_ERASE);
    ev_char_req  = rx_pop && (kind == BK_CHAR);
    char_up      = fold_upper(rx_byte);
  end

endmodule

// File: rtl/cle_line_store.sv
module cle_line_store
  import cle_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [CHAR_W-1:0] push_char,
  input  logic              erase,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CHAR_W-1:0] rd_char,
  output logic [LEN_W-1:0]  len,
  output logic              is_full,
  output logic              is_empty
);

  logic [CHAR_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_sel;
    assign wr_sel = push && (len == LEN_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (wr_sel)
        slot[g] <= push_char;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      len <= '0;
    else if (clear)
      len <= '0;
    else if (push)
      len <= len + 1'b1;
    else if (erase)
      len <= len - 1'b1;
  end

  always_comb begin
    is_full  = (len == LEN_W'(DEPTH));
    is_empty = (len == '0);
    rd_char  = (32'(rd_idx) < DEPTH) ? slot[rd_idx] : '0;
  end

endmodule

// File: rtl/cle_echo.sv
module cle_echo
  import cle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_char,
  input  logic              send_erase,
  input  logic [CHAR_W-1:0] char_in,
  output logic              echo_wr,
  output logic [CHAR_W-1:0] echo_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_wr   <= 1'b0;
      echo_byte <= '0;
    end else begin
      echo_wr <= send_char | send_erase;
      if (send_erase)
        echo_byte <= CH_BS;
      else if (send_char)
        echo_byte <= char_in;
    end
  end

endmodule

// File: rtl/cmd_line_editor.sv
module cmd_line_editor
  import cle_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              rx_present,
  input  logic              rx_full,
  output logic              rx_pop,
  input  logic              tx_full,
  output logic [CHAR_W-1:0] echo_byte,
  output logic              echo_wr,
  input  logic              line_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CHAR_W-1:0] rd_char,
  output logic [LEN_W-1:0]  line_len,
  output logic              line_ready,
  output logic              line_long,
  output logic              overflow
);

  // Named internal events, used by the checker.
  logic              ev_end;
  logic              ev_erase_req;
  logic              ev_char_req;
  logic              ev_store;
  logic              ev_erase;
  logic              ev_drop;
  logic [CHAR_W-1:0] char_up;
  logic              buf_full;
  logic              buf_empty;

  cle_rx_gate u_gate (
    .rx_byte      (rx_byte),
    .rx_present   (rx_present),
    .tx_full      (tx_full),
    .line_ready   (line_ready),
    .line_done    (line_done),
    .rx_pop       (rx_pop),
    .ev_end       (ev_end),
    .ev_erase_req (ev_erase_req),
    .ev_char_req  (ev_char_req),
    .char_up      (char_up)
  );

  assign ev_store = ev_char_req & ~buf_full;
  assign ev_drop  = ev_char_req & buf_full;
  assign ev_erase = ev_erase_req & ~buf_empty;

  cle_line_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (line_done),
    .push      (ev_store),
    .push_char (char_up),
    .erase     (ev_erase),
    .rd_idx    (rd_idx),
    .rd_char   (rd_char),
    .len       (line_len),
    .is_full   (buf_full),
    .is_empty  (buf_empty)
  );

  cle_echo u_echo (
    .clk        (clk),
    .rst_n      (rst_n),
    .send_char  (ev_store),
    .send_erase (ev_erase),
    .char_in    (char_up),
    .echo_wr    (echo_wr),
    .echo_byte  (echo_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ready <= 1'b0;
      line_long  <= 1'b0;
      overflow   <= 1'b0;
    end else if (line_done) begin
      line_ready <= 1'b0;
      line_long  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      if (ev_end)
        line_ready <= 1'b1;
      if (ev_drop)
        line_long <= 1'b1;
      if (rx_full)
        overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/cle_checker.sv
module cle_checker #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rx_byte,
  input logic             rx_present,
  input logic             rx_full,
  input logic             rx_pop,
  input logic             tx_full,
  input logic             line_done,
  input logic             echo_wr,
  input logic [7:0]       echo_byte,
  input logic [LEN_W-1:0] line_len,
  input logic             line_ready,
  input logic             overflow,
  input logic             ev_store,
  input logic             ev_erase
);

  a_r1_pop_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rx_present && !tx_full));

  a_r2_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    line_len <= LEN_W'(DEPTH));

  a_r2_store_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && !line_done) |=> (line_len == $past(line_len) + 1'b1));

  a_r4_erase_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_erase && !line_done) |=> (line_len + 1'b1 == $past(line_len)));

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_byte == 8'h08 && line_len == '0) |=> (line_len == '0 && !echo_wr));

  a_r6_end_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_byte == 8'h0D) |=> line_ready);

  a_r7_ready_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |-> !rx_pop);

  a_r7_ready_freezes_len: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ready && !line_done) |=> $stable(line_len));

  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (line_len == '0 && !line_ready && !overflow));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !line_done) |=> overflow);

  a_r10_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !line_done) |=> overflow);

  a_r11_echo_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store || ev_erase) |=> echo_wr);

  a_r11_echo_single: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_wr && !$past(rx_pop)) |-> 1'b0);

endmodule

bind cmd_line_editor cle_checker #(.DEPTH(DEPTH)) u_cle_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_byte    (rx_byte),
  .rx_present (rx_present),
  .rx_full    (rx_full),
  .rx_pop     (rx_pop),
  .tx_full    (tx_full),
  .line_done  (line_done),
  .echo_wr    (echo_wr),
  .echo_byte  (echo_byte),
  .line_len   (line_len),
  .line_ready (line_ready),
  .overflow   (overflow),
  .ev_store   (ev_store),
  .ev_erase   (ev_erase)
);

// File: tb/cmd_line_editor_tb_top.sv
module cmd_line_editor_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_present = 1'b0;
  logic       rx_full = 1'b0;
  logic       rx_pop;
  logic       tx_full = 1'b0;
  logic [7:0] echo_byte;
  logic       echo_wr;
  logic       line_done = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_char;
  logic [4:0] line_len;
  logic       line_ready;
  logic       line_long;
  logic       overflow;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_line [DEPTH];
  int         m_len   = 0;
  bit         m_ready = 0;
  bit         m_long  = 0;
  bit         m_ovf   = 0;

  always #5 clk = ~clk;

  cmd_line_editor #(.DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_byte    (rx_byte),
    .rx_present (rx_present),
    .rx_full    (rx_full),
    .rx_pop     (rx_pop),
    .tx_full    (tx_full),
    .echo_byte  (echo_byte),
    .echo_wr    (echo_wr),
    .line_done  (line_done),
    .rd_idx     (rd_idx),
    .rd_char    (rd_char),
    .line_len   (line_len),
    .line_ready (line_ready),
    .line_long  (line_long),
    .overflow   (overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_print(input logic [7:0] b);
    return (b > 8'h1F) && (b < 8'h7F);
  endfunction

  function automatic logic [7:0] to_upper(input logic [7:0] b);
    if (b inside {[8'h61:8'h7A]}) return b & 8'hDF;
    return b;
  endfunction

  task automatic check_flags(input string req);
    chk(line_len == 5'(m_len), {req, " len"}, line_len, m_len);
    chk(line_ready == m_ready, {req, " ready"}, line_ready, m_ready);
    chk(line_long == m_long, {req, " long"}, line_long, m_long);
    chk(overflow == m_ovf, {req, " overflow"}, overflow, m_ovf);
  endtask

  // Offer one byte for one cycle and check pop, echo and state.
  task automatic send(input logic [7:0] b, input bit txf, input string req);
    bit         e_pop;
    bit         e_echo = 0;
    logic [7:0] e_eb = '0;
    @(negedge clk);
    chk(echo_wr == 1'b0, "R11 echo single cycle", echo_wr, 0);
    rx_byte = b; rx_present = 1'b1; tx_full = txf;
    #1;
    e_pop = !txf && !m_ready;
    chk(rx_pop == e_pop, "R1 pop handshake", rx_pop, e_pop);
    if (e_pop) begin
      if (b == 8'h0D) m_ready = 1;
      else if (b == 8'h08) begin
        if (m_len > 0) begin m_len--; e_echo = 1; e_eb = 8'h08; end
      end else if (is_print(b)) begin
        if (m_len < DEPTH) begin
          m_line[m_len] = to_upper(b); m_len++; e_echo = 1; e_eb = to_upper(b);
        end else m_long = 1;
      end
    end
    @(posedge clk); #1;
    rx_present = 1'b0; tx_full = 1'b0;
    @(negedge clk);
    chk(echo_wr == e_echo, {req, " R11 echo strobe"}, echo_wr, e_echo);
    if (e_echo) chk(echo_byte == e_eb, {req, " R3 echo byte"}, echo_byte, e_eb);
    check_flags(req);
  endtask

  task automatic send_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b0, req);
  endtask

  task automatic read_back(input string req);
    for (int i = 0; i < m_len; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      chk(rd_char == m_line[i], {req, " R13 read"}, rd_char, m_line[i]);
    end
  endtask

  task automatic finish_line(input string req);
    @(negedge clk);
    line_done = 1'b1;
    rx_present = 1'b1;
    #1;
    chk(rx_pop == 1'b0, "R1 no pop during done", rx_pop, 0);
    @(posedge clk); #1;
    line_done = 1'b0; rx_present = 1'b0;
    m_len = 0; m_ready = 0; m_long = 0; m_ovf = 0;
    @(negedge clk);
    check_flags({req, " R8 clear"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("reset");
    chk(echo_wr == 1'b0, "reset echo", echo_wr, 0);
    chk(rx_pop == 1'b0, "R1 reset pop", rx_pop, 0);

    // R2 R3: mixed case line, closed with CR (R6).
    send_str("tIme 1z", "R2 R3 store");
    send(8'h0D, 1'b0, "R6 end");
    read_back("R2 R3");
    // R7: present held while ready
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_byte = "x"; rx_present = 1'b1;
      #1;
      chk(rx_pop == 1'b0, "R7 held off", rx_pop, 0);
    end
    @(negedge clk);
    rx_present = 1'b0;
    check_flags("R7 frozen");
    finish_line("R8");

    // R5: backspace on empty line
    send(8'h08, 1'b0, "R5 empty erase");
    send(8'h08, 1'b0, "R5 empty erase again");
    // R4: erase in mid line
    send_str("ab", "R4 setup");
    send(8'h08, 1'b0, "R4 erase");
    send_str("c", "R4 after");
    read_back("R4");
    // R12: junk bytes
    send(8'h07, 1'b0, "R12 bell");
    send(8'h7F, 1'b0, "R12 delete");
    send(8'hC3, 1'b0, "R12 high");
    // R1: stall by transmit full
    send("q", 1'b1, "R1 tx stall");
    send(8'h0D, 1'b0, "R6 end 2");
    finish_line("R8 second");

    // R9: overlong line
    send_str("abcdefghijklmnopqr", "R9 long");
    chk(line_long == 1'b1, "R9 long flag", line_long, 1);
    read_back("R9");
    send(8'h08, 1'b0, "R9 erase after full");
    send_str("s", "R9 refill");
    send(8'h0D, 1'b0, "R6 end 3");
    finish_line("R8 third");

    // R10: overflow sticky
    @(negedge clk); rx_full = 1'b1;
    @(posedge clk); #1; rx_full = 1'b0;
    m_ovf = 1;
    @(negedge clk); check_flags("R10 set");
    repeat (3) @(negedge clk);
    check_flags("R10 sticky");
    finish_line("R8 overflow");

    // Random stream
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] b;
      bit txf = 0;
      if (r < 40)      b = 8'(8'h61 + $urandom_range(0, 25));
      else if (r < 52) b = 8'(8'h41 + $urandom_range(0, 25));
      else if (r < 58) b = 8'(8'h30 + $urandom_range(0, 9));
      else if (r < 64) b = 8'h20;
      else if (r < 76) b = 8'h08;
      else if (r < 82) b = 8'h0D;
      else if (r < 90) b = 8'($urandom_range(0, 31)) | 8'h80;
      else begin b = 8'(8'h61 + $urandom_range(0, 25)); txf = 1; end
      send(b, txf, "random");
      if (m_ready) begin
        read_back("random");
        finish_line("random R8");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule